// File: doc/BRIEF.md
# Byte-Port Frame Buffer

This block sits between a host processor and a network frame stream. It holds one receive frame and one transmit frame, each up to 1514 bytes, behind a small register window on a synchronous bus with address, write strobe, read strobe and 32-bit data. Read data is registered and appears in the cycle after the read strobe. The host drains a received frame one byte per read of a data port. It builds a transmit frame by programming a length and then writing one byte per write to a second data port.

On the network side, received frames arrive on a valid/data/last stream with a ready back-pressure signal. A frame is either taken whole or refused whole. Transmit frames leave on a valid/data/last stream that waits for ready on every byte. A level interrupt is high while any pending-event bit is set. A busy flag gates reception, and the host's writes to the event register decide when it drops.

The receive path is a three-state machine. RX_IDLE offers ready only when reception is allowed. The first byte of a frame moves it to RX_FILL, or to RX_DROP when the frame is too long. RX_FILL moves to RX_DROP if the frame grows past the limit or a soft reset hits mid-frame. Both RX_FILL and RX_DROP return to RX_IDLE on the last byte. The transmit path has two states. TX_LOAD collects host bytes and moves to TX_SEND when the frame is complete. TX_SEND returns to TX_LOAD after the handshake on the last byte.

Top module: `pktport_top`

## Requirements
- R1: After reset the busy register reads 1, both byte counts and the event register read 0, irq is low and rx_ready is low.
- R2: Only address bits [5:0] are decoded. Offset 0x00 reads 0x504B5442 and offset 0x04 reads 0x55463031. Offsets 0x18, 0x20 and every unmapped offset read 0. Writes to the identification, busy, receive count, info and receive data offsets change nothing.
- R3: The event register at 0x14 has tx-done at bit 0, rx-done at bit 1 and test at bit 31. irq is high exactly when any of these bits is set.
- R4: A write to 0x14 is decoded by priority. Bit 0 clears only tx-done. Otherwise bit 1 clears only rx-done. Otherwise bit 31 soft-resets. A write of 0 changes no bit. After the write, busy (0x08) equals 1 if any event bit remains set and 0 otherwise.
- R5: A soft reset clears both byte counts, both pointers and the event bits, then sets the test bit and busy. A read of 0x14 returns the value before the read and then clears the test bit.
- R6: rx_ready is high in RX_IDLE only when busy is 0 and the receive count is below 1514.
- R7: An accepted frame is stored from offset 0. The receive count (0x0C) becomes its length, the read pointer returns to 0, rx-done is set and busy is set.
- R8: A received frame of 1514 bytes or more is consumed and discarded, with no change to count, events or busy. A 1513-byte frame is accepted.
- R9: Each read of 0x1C while the count is non-zero returns the byte at the read pointer, advances the pointer and decrements the count. With the count at 0 it returns 0 and changes nothing.
- R10: A write to 0x10 loads the value if it is at most 1514 and 0 otherwise, and it returns the transmit write pointer to 0.
- R11: Each write to 0x20 stores bits [7:0] at the write pointer and advances it. When the pointer reaches the programmed count, or reaches 1514, the frame is sent with that many bytes. The count and pointer then clear and tx-done and busy are set. Writes to 0x20 are ignored while a frame is streaming out.
- R12: Transmit bytes leave in write order on tx_data. tx_last is high only on the final byte, and valid, data and last hold steady while tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address, low 6 bits decoded |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Level interrupt, any event bit set |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Final byte of the receive frame |
| rx_ready | output | 1 | Block takes the receive byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the transmit frame |
| tx_ready | input | 1 | Sink takes the transmit byte |

## Verification
Register reads return in the cycle after the strobe, so the bench raises the strobe at a falling edge and samples bus_rdata at the next falling edge. Read side effects, such as the test-bit clear and the receive pop, are therefore visible to the next read. A frame commit, a transmit completion and a soft reset all update counts, events, busy and irq at the rising edge of their final handshake or write. The bench checks them only through later register reads, which always come at least one cycle after that edge. The transmit stream starts one cycle after the completing write. A falling-edge monitor records every byte where tx_valid and tx_ready are both high, and the bench compares the recorded frame against the written bytes once the frame-end count advances.

// File: rtl/pktport_pkg.sv
package pktport_pkg;

    localparam logic [5:0] OFF_ID0    = 6'h00;
    localparam logic [5:0] OFF_ID1    = 6'h04;
    localparam logic [5:0] OFF_BUSY   = 6'h08;
    localparam logic [5:0] OFF_RXCNT  = 6'h0C;
    localparam logic [5:0] OFF_TXCNT  = 6'h10;
    localparam logic [5:0] OFF_EVENT  = 6'h14;
    localparam logic [5:0] OFF_INFO   = 6'h18;
    localparam logic [5:0] OFF_RXDATA = 6'h1C;
    localparam logic [5:0] OFF_TXDATA = 6'h20;

    localparam int EV_TXDONE = 0;
    localparam int EV_RXDONE = 1;
    localparam int EV_TEST   = 31;

    localparam logic [31:0] ID_WORD0 = 32'h504B_5442;
    localparam logic [31:0] ID_WORD1 = 32'h5546_3031;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_DROP = 2'd2
    } rx_state_t;

    typedef enum logic {
        TX_LOAD = 1'b0,
        TX_SEND = 1'b1
    } tx_state_t;

endpackage

// File: rtl/pktport_rx.sv
module pktport_rx
    import pktport_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             busy,
    input  logic             pop,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             in_ready,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       rd_byte,
    output logic             commit
);

    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_FRAME - 1);
    localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(MAX_FRAME);

    rx_state_t        state, nxt;
    logic [CNT_W-1:0] fill_idx, cur_idx, rd_ptr;
    logic [7:0]       mem [MAX_FRAME];
    logic             hs, take, over;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt      = state;
        in_ready = 1'b0;
        unique case (state)
            RX_IDLE: in_ready = !busy && (count < LIMIT);
            RX_FILL: in_ready = 1'b1;
            RX_DROP: in_ready = 1'b1;
            default: in_ready = 1'b0;
        endcase
        hs      = in_valid && in_ready;
        cur_idx = (state == RX_IDLE) ? '0 : fill_idx;
        take    = hs && (state != RX_DROP);
        over    = take && (cur_idx == LAST_SLOT);
        commit  = take && in_last && !over && !soft_clr;
        unique case (state)
            RX_IDLE: if (take && !in_last) nxt = (over || soft_clr) ? RX_DROP : RX_FILL;
            RX_FILL: begin
                if (take)          nxt = in_last ? RX_IDLE : ((over || soft_clr) ? RX_DROP : RX_FILL);
                else if (soft_clr) nxt = RX_DROP;
            end
            RX_DROP: if (hs && in_last) nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (take && !over) mem[cur_idx] <= in_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fill_idx <= '0;
        else if (take) fill_idx <= cur_idx + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            count  <= '0;
            rd_ptr <= '0;
        end else if (commit) begin
            count  <= cur_idx + 1'b1;
            rd_ptr <= '0;
        end else if (pop && count != '0) begin
            count  <= count - 1'b1;
            rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign rd_byte = (count != '0) ? mem[rd_ptr] : 8'h00;

    AST_RX_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count < LIMIT); // R8
    AST_RX_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && in_ready) |-> !busy); // R6
    AST_RX_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !commit && !soft_clr) |=> (count == $past(count) - 1'b1)); // R9

endmodule

// File: rtl/pktport_tx.sv
module pktport_tx
    import pktport_pkg::*;
#(
    parameter int MAX_FRAME = 1514,
    parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_clr,
    input  logic             cnt_wr,
    input  logic             data_wr,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last,
    input  logic             out_ready
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_FRAME);

    tx_state_t        state, nxt;
    logic [CNT_W-1:0] wr_ptr, nxt_ptr, send_len, send_idx;
    logic [7:0]       mem [MAX_FRAME];
    logic             take_byte, fin;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_LOAD;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        out_valid = 1'b0;
        out_last  = 1'b0;
        out_data  = 8'h00;
        take_byte = data_wr && (state == TX_LOAD);
        nxt_ptr   = wr_ptr + 1'b1;
        fin       = take_byte && !soft_clr && ((nxt_ptr == count) || (nxt_ptr >= LIMIT));
        unique case (state)
            TX_LOAD: if (fin) nxt = TX_SEND;
            TX_SEND: begin
                out_valid = 1'b1;
                out_data  = mem[send_idx];
                out_last  = (send_idx == send_len - 1'b1);
                if (out_ready && out_last) nxt = TX_LOAD;
            end
            default: nxt = TX_LOAD;
        endcase
    end

    assign done = fin;

    always_ff @(posedge clk) begin
        if (take_byte) mem[wr_ptr] <= wdata[7:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            count  <= '0;
            wr_ptr <= '0;
        end else if (fin) begin
            count  <= '0;
            wr_ptr <= '0;
        end else if (cnt_wr) begin
            count  <= (wdata <= 32'(MAX_FRAME)) ? wdata[CNT_W-1:0] : '0;
            wr_ptr <= '0;
        end else if (take_byte) begin
            wr_ptr <= nxt_ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            send_len <= '0;
            send_idx <= '0;
        end else if (fin) begin
            send_len <= nxt_ptr;
            send_idx <= '0;
        end else if (state == TX_SEND && out_ready && !out_last) begin
            send_idx <= send_idx + 1'b1;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R12
    AST_TX_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LIMIT); // R10
    AST_TX_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr < LIMIT); // R11

endmodule

// File: rtl/pktport_top.sv
module pktport_top
    import pktport_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MAX_FRAME = 1514
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    input  logic              tx_ready
);

    localparam int CNT_W = $clog2(MAX_FRAME + 1);

    logic [5:0]       offs;
    logic             unused_addr_hi;
    logic             ev_tx, ev_rx, ev_test, busy;
    logic             n_tx, n_rx, n_test, n_busy;
    logic             wr_event, rd_event, soft_clr, rx_pop;
    logic             rx_commit, tx_done;
    logic [CNT_W-1:0] rx_count, tx_count;
    logic [7:0]       rx_byte;
    logic [31:0]      rd_mux;

    assign offs           = bus_addr[5:0];
    assign unused_addr_hi = ^bus_addr;
    assign wr_event       = bus_wr && offs == OFF_EVENT;
    assign rd_event       = bus_rd && offs == OFF_EVENT;
    assign soft_clr       = wr_event && !bus_wdata[EV_TXDONE] && !bus_wdata[EV_RXDONE] && bus_wdata[EV_TEST];
    assign rx_pop         = bus_rd && offs == OFF_RXDATA;

    pktport_rx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_clr (soft_clr),
        .busy     (busy),
        .pop      (rx_pop),
        .in_valid (rx_valid),
        .in_data  (rx_data),
        .in_last  (rx_last),
        .in_ready (rx_ready),
        .count    (rx_count),
        .rd_byte  (rx_byte),
        .commit   (rx_commit)
    );

    pktport_tx #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_clr  (soft_clr),
        .cnt_wr    (bus_wr && offs == OFF_TXCNT),
        .data_wr   (bus_wr && offs == OFF_TXDATA),
        .wdata     (bus_wdata),
        .count     (tx_count),
        .done      (tx_done),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .out_last  (tx_last),
        .out_ready (tx_ready)
    );

    // event and busy update: read clear, prioritised write, then new events
    always_comb begin
        n_tx   = ev_tx;
        n_rx   = ev_rx;
        n_test = ev_test;
        n_busy = busy;
        if (rd_event) n_test = 1'b0;
        if (wr_event) begin
            if (bus_wdata[EV_TXDONE])      n_tx = 1'b0;
            else if (bus_wdata[EV_RXDONE]) n_rx = 1'b0;
            else if (bus_wdata[EV_TEST]) begin
                n_tx   = 1'b0;
                n_rx   = 1'b0;
                n_test = 1'b1;
            end
            n_busy = n_tx || n_rx || n_test;
        end
        if (tx_done) begin
            n_tx   = 1'b1;
            n_busy = 1'b1;
        end
        if (rx_commit) begin
            n_rx   = 1'b1;
            n_busy = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_tx   <= 1'b0;
            ev_rx   <= 1'b0;
            ev_test <= 1'b0;
            busy    <= 1'b1;
        end else begin
            ev_tx   <= n_tx;
            ev_rx   <= n_rx;
            ev_test <= n_test;
            busy    <= n_busy;
        end
    end

    always_comb begin
        case (offs)
            OFF_ID0:    rd_mux = ID_WORD0;
            OFF_ID1:    rd_mux = ID_WORD1;
            OFF_BUSY:   rd_mux = {31'b0, busy};
            OFF_RXCNT:  rd_mux = 32'(rx_count);
            OFF_TXCNT:  rd_mux = 32'(tx_count);
            OFF_EVENT:  rd_mux = {ev_test, 29'b0, ev_rx, ev_tx};
            OFF_RXDATA: rd_mux = {24'b0, rx_byte};
            default:    rd_mux = 32'h0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= 32'h0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= 32'h0;
    end

    assign irq = ev_tx || ev_rx || ev_test;

    AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> busy); // R3
    AST_SOFT_RESET_TEST: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (ev_test && busy && rx_count == '0 && tx_count == '0)); // R5
    AST_TXCLR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_event && bus_wdata[EV_TXDONE] && !tx_done && !rx_commit) |=> (!ev_tx && ev_rx == $past(ev_rx))); // R4

endmodule

// File: tb/tb_pktport_top.sv
module tb_pktport_top;

    localparam int MAXF = 1514;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        tx_valid, tx_last;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    int errors = 0;
    int checks = 0;
    int txn = 0;
    int txframes = 0;
    int txlen = 0;
    int cyc = 0;
    bit stall_mode = 1'b0;
    logic [7:0] txcap [0:2047];

    always #10 clk = ~clk;

    pktport_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    // transmit stream monitor, runs at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        tx_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
            txcap[txn] = tx_data;
            txn = txn + 1;
            if (tx_last) begin
                txlen = txn;
                txframes = txframes + 1;
            end
        end
    end

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 31) + (i * 7) + (i >> 8));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rx_frame(input int len, input int seed);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            rx_valid = 1'b1;
            rx_data  = pat(seed, i);
            rx_last  = (i == len - 1);
            while (!rx_ready) @(negedge clk);
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic tx_bytes(input int n, input int seed);
        for (int i = 0; i < n; i++) bus_write(8'h20, 32'hABCD_EF00 | 32'(pat(seed, i)));
    endtask

    task automatic wait_frame(input int target);
        for (int k = 0; k < 4000 && txframes < target; k++) @(negedge clk);
    endtask

    task automatic check_tx(input string req, input int n, input int seed);
        int bad;
        bad = 0;
        chk(req, 32'(txlen), 32'(n));
        for (int i = 0; i < n; i++) if (txcap[i] !== pat(seed, i)) bad++;
        chk(req, 32'(bad), 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_read(8'h08, d); chk("R1 busy", d, 32'd1);
        bus_read(8'h0C, d); chk("R1 rxcount", d, 32'd0);
        bus_read(8'h10, d); chk("R1 txcount", d, 32'd0);
        bus_read(8'h14, d); chk("R1 events", d, 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        bus_read(8'h00, d); chk("R2 id0", d, 32'h504B_5442);
        bus_read(8'h44, d); chk("R2 id1 masked", d, 32'h5546_3031);
        bus_read(8'h18, d); chk("R2 info", d, 32'd0);
        bus_read(8'h20, d); chk("R2 txdata read", d, 32'd0);
        bus_read(8'h30, d); chk("R2 unmapped", d, 32'd0);
        bus_write(8'h08, 32'd0);
        bus_write(8'h0C, 32'h55);
        bus_write(8'h00, 32'h1234);
        bus_read(8'h08, d); chk("R2 busy read-only", d, 32'd1);
        bus_read(8'h0C, d); chk("R2 rxcount read-only", d, 32'd0);
        bus_read(8'h00, d); chk("R2 id0 read-only", d, 32'h504B_5442);
    endtask

    task automatic t_rx_basic;
        logic [31:0] d;
        bus_write(8'h14, 32'd0);
        bus_read(8'h08, d); chk("R4 zero write busy", d, 32'd0);
        chk("R6 ready when idle", 32'(rx_ready), 32'd1);
        rx_frame(5, 3);
        bus_read(8'h0C, d); chk("R7 rxcount", d, 32'd5);
        bus_read(8'h08, d); chk("R7 busy", d, 32'd1);
        bus_read(8'h14, d); chk("R7 rxdone", d, 32'd2);
        chk("R3 irq rxdone", 32'(irq), 32'd1);
        chk("R6 ready blocked by busy", 32'(rx_ready), 32'd0);
        for (int i = 0; i < 5; i++) begin
            bus_read(8'h1C, d); chk("R9 rx byte", d, 32'(pat(3, i)));
        end
        bus_read(8'h0C, d); chk("R9 count drained", d, 32'd0);
        bus_read(8'h1C, d); chk("R9 empty read", d, 32'd0);
        bus_read(8'h0C, d); chk("R9 empty no change", d, 32'd0);
        bus_write(8'h14, 32'd2);
        bus_read(8'h14, d); chk("R4 rxdone cleared", d, 32'd0);
        bus_read(8'h08, d); chk("R4 busy follows", d, 32'd0);
        chk("R3 irq low", 32'(irq), 32'd0);
    endtask

    task automatic t_tx_basic;
        logic [31:0] d;
        stall_mode = 1'b1;
        txn = 0;
        bus_write(8'h10, 32'd3);
        bus_read(8'h10, d); chk("R10 txcount load", d, 32'd3);
        tx_bytes(3, 9);
        wait_frame(1);
        check_tx("R12 stream frame", 3, 9);
        bus_read(8'h14, d); chk("R11 txdone", d, 32'd1);
        bus_read(8'h10, d); chk("R11 count cleared", d, 32'd0);
        bus_read(8'h08, d); chk("R11 busy", d, 32'd1);
        stall_mode = 1'b0;
    endtask

    task automatic t_priority;
        logic [31:0] d;
        bus_write(8'h14, 32'd1);
        bus_read(8'h08, d); chk("R4 busy after txclr", d, 32'd0);
        rx_frame(2, 5);
        txn = 0;
        bus_write(8'h10, 32'd2);
        tx_bytes(2, 6);
        wait_frame(2);
        bus_read(8'h14, d); chk("R3 both events", d, 32'd3);
        bus_write(8'h14, 32'd3);
        bus_read(8'h14, d); chk("R4 bit0 wins", d, 32'd2);
        bus_read(8'h08, d); chk("R4 busy stays", d, 32'd1);
        bus_write(8'h14, 32'h8000_0001);
        bus_read(8'h14, d); chk("R4 bit0 beats test", d, 32'd2);
        bus_write(8'h14, 32'd2);
        bus_read(8'h14, d); chk("R4 all clear", d, 32'd0);
        bus_read(8'h08, d); chk("R4 busy clear", d, 32'd0);
    endtask

    task automatic t_txcount;
        logic [31:0] d;
        bus_write(8'h10, 32'd2000);
        bus_read(8'h10, d); chk("R10 oversize count", d, 32'd0);
        bus_write(8'h10, 32'd1514);
        bus_read(8'h10, d); chk("R10 max count", d, 32'd1514);
        bus_write(8'h10, 32'd1515);
        bus_read(8'h10, d); chk("R10 max plus one", d, 32'd0);
        txn = 0;
        bus_write(8'h10, 32'd4);
        tx_bytes(2, 11);
        bus_write(8'h10, 32'd2);
        tx_bytes(2, 12);
        wait_frame(3);
        check_tx("R10 pointer reset", 2, 12);
        bus_write(8'h14, 32'd1);
    endtask

    task automatic t_softreset;
        logic [31:0] d;
        rx_frame(4, 7);
        bus_write(8'h14, 32'd2);
        bus_write(8'h10, 32'd7);
        bus_read(8'h0C, d); chk("R7 count before soft reset", d, 32'd4);
        bus_write(8'h14, 32'h8000_0000);
        chk("R5 irq test", 32'(irq), 32'd1);
        bus_read(8'h14, d); chk("R5 test set", d, 32'h8000_0000);
        bus_read(8'h14, d); chk("R5 test cleared by read", d, 32'd0);
        chk("R3 irq after read", 32'(irq), 32'd0);
        bus_read(8'h0C, d); chk("R5 rxcount cleared", d, 32'd0);
        bus_read(8'h10, d); chk("R5 txcount cleared", d, 32'd0);
        bus_read(8'h08, d); chk("R5 busy", d, 32'd1);
        bus_write(8'h14, 32'd0);
        bus_read(8'h08, d); chk("R4 busy after zero", d, 32'd0);
    endtask

    task automatic t_rx_bound;
        logic [31:0] d;
        rx_frame(MAXF, 2);
        bus_read(8'h0C, d); chk("R8 dropped count", d, 32'd0);
        bus_read(8'h14, d); chk("R8 dropped events", d, 32'd0);
        bus_read(8'h08, d); chk("R8 dropped busy", d, 32'd0);
        rx_frame(MAXF - 1, 4);
        bus_read(8'h0C, d); chk("R8 1513 accepted", d, 32'(MAXF - 1));
        bus_read(8'h1C, d); chk("R9 first byte", d, 32'(pat(4, 0)));
        bus_read(8'h0C, d); chk("R9 count decrement", d, 32'(MAXF - 2));
        bus_write(8'h14, 32'd2);
        chk("R6 ready with count below limit", 32'(rx_ready), 32'd1);
        rx_frame(3, 8);
        bus_read(8'h0C, d); chk("R7 overwrite count", d, 32'd3);
        bus_read(8'h1C, d); chk("R7 stored from offset 0", d, 32'(pat(8, 0)));
        bus_write(8'h14, 32'd2);
    endtask

    task automatic t_tx_cap;
        logic [31:0] d;
        txn = 0;
        bus_write(8'h10, 32'd0);
        tx_bytes(MAXF, 13);
        wait_frame(4);
        check_tx("R11 cap at 1514", MAXF, 13);
        bus_read(8'h14, d); chk("R11 cap txdone", d, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regmap;
        t_rx_basic;
        t_tx_basic;
        t_priority;
        t_txcount;
        t_softreset;
        t_rx_bound;
        t_tx_cap;
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule